// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block gathers interrupt events from two subordinate groups and from directly driven source bits into one interrupt line. Each subordinate group has a pending word that software can set, clear and read back, and a mask word. The group for the attached USB core is split into two halves. The lower half raises a transmit summary flag and the upper half raises a receive summary flag. The group for DMA completions raises a single summary flag. These flags take fixed positions in a 32-bit main pending word. The main word has its own set, clear and mask controls.

One control bit selects how the line is formed. With the bit set, the line is active while any unmasked main bit is pending. With the bit clear, the line is active only while nothing unmasked is pending. In both cases the line is also gated by a power-up enable. When power is applied, the enable drops at once. It returns after a fixed number of clock cycles, and only if power has stayed on for that whole time. The line leaves a register, so it never glitches. Every register write, and every hardware event, reaches the line on the same clock edge that updates the register.

Top module: `irq_aggr_top`

## Requirements
- R1: After reset the main mask reads 0xFFFFFFFF. The two group masks, all pending words and the control word read 0, and `irq_o` is low.
- R2: Writing a set address ORs the data into that pending word, and writing a clear address clears the pending bits where the data has ones. Reading the source, set or clear address of a word returns its pending value.
- R3: Main bit 9 is 1 exactly when some unmasked bit in core group bits 15:0 is pending. Main bit 8 is 1 exactly when some unmasked bit in core group bits 31:16 is pending. A group mask bit of 1 hides its bit.
- R4: Main bit 24 is 1 exactly when some unmasked DMA group bit is pending.
- R5: A main mask bit of 1 removes that main bit from the line decision, and the summary bits are masked like any other bit.
- R6: With control bit 0 set to 1, `irq_o` is high exactly when the power-up enable is on and some unmasked main bit is pending.
- R7: With control bit 0 set to 0, `irq_o` is high exactly when the power-up enable is on and no unmasked main bit is pending.
- R8: On a low-to-high change of `pwr_i`, the power-up enable drops on that clock edge and comes back HOLD_CYCLES edges later, provided `pwr_i` stayed high throughout. A power drop during the hold-off cancels the return. A power drop after the enable is on leaves the enable on.
- R9: A write to any set, clear, mask or control address changes `irq_o` on the same clock edge that stores the write.
- R10: A one on `main_hw_set`, `core_hw_set` or `dma_hw_set` sets that pending bit, even when a clear write to the same bit lands on the same edge.
- R11: The addresses used are 0 to 4 (main source, set, clear, mask, control), 8 to 11 (core source, set, clear, mask) and 12 to 15 (DMA source, set, clear, mask). Any other address reads 0, and writes to it change no state.
- R12: Main bits 8, 9 and 24 always show their group summaries. Set or clear writes to those positions have no visible effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| main_hw_set | input | DW | Hardware set pulses for main pending bits |
| core_hw_set | input | DW | Hardware set pulses for core group bits |
| dma_hw_set | input | DW | Hardware set pulses for DMA group bits |
| pwr_i | input | 1 | Power-applied level |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions watch, on every cycle, that the three summary bits agree with their group words and masks. They also check that the line matches the active polarity formula for the current pending word, mask and enable, that a power rise forces the line low on the next cycle, and that a clear write leaves no written bit pending. The bench scenarios cover what a per-cycle relation cannot show. These are the exact length of the hold-off, its cancellation by a power drop, and an enable that survives a power drop. They also include read-back through the set and clear aliases, hardware set winning over a clear on the same edge, and writes to summary positions or unused addresses having no effect.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    // Word addresses of the register port
    localparam int unsigned A_MAIN_SRC  = 0;
    localparam int unsigned A_MAIN_SET  = 1;
    localparam int unsigned A_MAIN_CLR  = 2;
    localparam int unsigned A_MAIN_MASK = 3;
    localparam int unsigned A_CTRL      = 4;
    localparam int unsigned A_CORE_SRC  = 8;
    localparam int unsigned A_CORE_SET  = 9;
    localparam int unsigned A_CORE_CLR  = 10;
    localparam int unsigned A_CORE_MASK = 11;
    localparam int unsigned A_DMA_SRC   = 12;
    localparam int unsigned A_DMA_SET   = 13;
    localparam int unsigned A_DMA_CLR   = 14;
    localparam int unsigned A_DMA_MASK  = 15;

    // Positions of the group summaries inside the main pending word
    localparam int unsigned TX_SUM_BIT  = 9;
    localparam int unsigned RX_SUM_BIT  = 8;
    localparam int unsigned DMA_SUM_BIT = 24;

    // Control word: bit 0 selects the line polarity formula
    localparam int unsigned CTRL_POL_BIT = 0;

    typedef struct packed {
        logic main_set;
        logic main_clr;
        logic main_mask;
        logic ctrl;
        logic core_set;
        logic core_clr;
        logic core_mask;
        logic dma_set;
        logic dma_clr;
        logic dma_mask;
    } wr_dec_t;

endpackage

// File: rtl/irq_aggr_group.sv
module irq_aggr_group #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NSUM = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_set,
    input  logic            wr_clr,
    input  logic            wr_mask,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   hw_set,
    output logic [DW-1:0]   src_q_o,
    output logic [DW-1:0]   mask_q_o,
    output logic [NSUM-1:0] sum_q_o,
    output logic [NSUM-1:0] sum_d_o
);

    localparam int unsigned SLICE = DW / NSUM;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] mask;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_set)  st_d.src  = st_q.src | wdata;
        if (wr_clr)  st_d.src  = st_d.src & ~wdata;
        st_d.src = st_d.src | hw_set;
        if (wr_mask) st_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // One summary flag per equal slice of the pending word
    for (genvar g = 0; g < NSUM; g++) begin : g_sum
        assign sum_d_o[g] = |(st_d.src[g*SLICE +: SLICE] & ~st_d.mask[g*SLICE +: SLICE]);
        assign sum_q_o[g] = |(st_q.src[g*SLICE +: SLICE] & ~st_q.mask[g*SLICE +: SLICE]);
    end

    assign src_q_o  = st_q.src;
    assign mask_q_o = st_q.mask;

endmodule

// File: rtl/irq_aggr_holdoff.sv
module irq_aggr_holdoff #(
    parameter int unsigned HOLD_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_i,
    output logic en_q_o,
    output logic en_d_o
);

    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic          pwr;
        logic          run;
        logic          en;
        logic [CW-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwr = pwr_i;
        if (pwr_i && !st_q.pwr) begin
            // Fresh power-up: close the gate and restart the count
            st_d.en  = 1'b0;
            st_d.run = 1'b1;
            st_d.cnt = CW'(HOLD_CYCLES - 1);
        end else if (!pwr_i) begin
            st_d.run = 1'b0;
        end else if (st_q.run) begin
            if (st_q.cnt == '0) begin
                st_d.run = 1'b0;
                st_d.en  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q_o = st_q.en;
    assign en_d_o = st_d.en;

endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
#(
    parameter int unsigned DW          = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned HOLD_CYCLES = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [DW-1:0]     main_hw_set,
    input  logic [DW-1:0]     core_hw_set,
    input  logic [DW-1:0]     dma_hw_set,
    input  logic              pwr_i,
    output logic              irq_o
);

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] mask;
        logic          pol;
        logic          irq;
    } main_st_t;

    main_st_t st_d, st_q;
    wr_dec_t  dec;

    logic [DW-1:0] core_src_q, core_mask_q, dma_src_q, dma_mask_q;
    logic [1:0]    core_sum_q, core_sum_d;
    logic [0:0]    dma_sum_q, dma_sum_d;
    logic          hold_en_q, hold_en_d;
    logic [DW-1:0] main_eff_q, main_eff_d, main_mask_q;
    logic          pol_q;

    // Write decode
    always_comb begin
        dec           = '0;
        dec.main_set  = reg_wr && (int'(reg_addr) == A_MAIN_SET);
        dec.main_clr  = reg_wr && (int'(reg_addr) == A_MAIN_CLR);
        dec.main_mask = reg_wr && (int'(reg_addr) == A_MAIN_MASK);
        dec.ctrl      = reg_wr && (int'(reg_addr) == A_CTRL);
        dec.core_set  = reg_wr && (int'(reg_addr) == A_CORE_SET);
        dec.core_clr  = reg_wr && (int'(reg_addr) == A_CORE_CLR);
        dec.core_mask = reg_wr && (int'(reg_addr) == A_CORE_MASK);
        dec.dma_set   = reg_wr && (int'(reg_addr) == A_DMA_SET);
        dec.dma_clr   = reg_wr && (int'(reg_addr) == A_DMA_CLR);
        dec.dma_mask  = reg_wr && (int'(reg_addr) == A_DMA_MASK);
    end

    // Core group: low half feeds the transmit flag, high half the receive flag
    irq_aggr_group #(.DW(DW), .NSUM(2)) core_grp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_set   (dec.core_set),
        .wr_clr   (dec.core_clr),
        .wr_mask  (dec.core_mask),
        .wdata    (reg_wdata),
        .hw_set   (core_hw_set),
        .src_q_o  (core_src_q),
        .mask_q_o (core_mask_q),
        .sum_q_o  (core_sum_q),
        .sum_d_o  (core_sum_d)
    );

    irq_aggr_group #(.DW(DW), .NSUM(1)) dma_grp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_set   (dec.dma_set),
        .wr_clr   (dec.dma_clr),
        .wr_mask  (dec.dma_mask),
        .wdata    (reg_wdata),
        .hw_set   (dma_hw_set),
        .src_q_o  (dma_src_q),
        .mask_q_o (dma_mask_q),
        .sum_q_o  (dma_sum_q),
        .sum_d_o  (dma_sum_d)
    );

    irq_aggr_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_i  (pwr_i),
        .en_q_o (hold_en_q),
        .en_d_o (hold_en_d)
    );

    // Main word, control and line: next state of everything feeds the line
    always_comb begin
        logic pend;
        st_d = st_q;
        if (dec.main_set)  st_d.src  = st_q.src | reg_wdata;
        if (dec.main_clr)  st_d.src  = st_d.src & ~reg_wdata;
        st_d.src = st_d.src | main_hw_set;
        if (dec.main_mask) st_d.mask = reg_wdata;
        if (dec.ctrl)      st_d.pol  = reg_wdata[CTRL_POL_BIT];

        main_eff_d              = st_d.src;
        main_eff_d[TX_SUM_BIT]  = core_sum_d[0];
        main_eff_d[RX_SUM_BIT]  = core_sum_d[1];
        main_eff_d[DMA_SUM_BIT] = dma_sum_d[0];

        pend     = |(main_eff_d & ~st_d.mask);
        st_d.irq = hold_en_d && (st_d.pol ? pend : !pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        main_eff_q              = st_q.src;
        main_eff_q[TX_SUM_BIT]  = core_sum_q[0];
        main_eff_q[RX_SUM_BIT]  = core_sum_q[1];
        main_eff_q[DMA_SUM_BIT] = dma_sum_q[0];
    end

    assign main_mask_q = st_q.mask;
    assign pol_q       = st_q.pol;
    assign irq_o       = st_q.irq;

    // Read path: set and clear addresses alias their source word
    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            A_MAIN_SRC, A_MAIN_SET, A_MAIN_CLR: reg_rdata = main_eff_q;
            A_MAIN_MASK:                        reg_rdata = st_q.mask;
            A_CTRL:                             reg_rdata[CTRL_POL_BIT] = st_q.pol;
            A_CORE_SRC, A_CORE_SET, A_CORE_CLR: reg_rdata = core_src_q;
            A_CORE_MASK:                        reg_rdata = core_mask_q;
            A_DMA_SRC, A_DMA_SET, A_DMA_CLR:    reg_rdata = dma_src_q;
            A_DMA_MASK:                         reg_rdata = dma_mask_q;
            default:                            reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
    import irq_aggr_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DW-1:0]     reg_wdata,
    input logic [DW-1:0]     core_hw_set,
    input logic              pwr_i,
    input logic              irq_o,
    input logic [DW-1:0]     core_src_q,
    input logic [DW-1:0]     core_mask_q,
    input logic [DW-1:0]     dma_src_q,
    input logic [DW-1:0]     dma_mask_q,
    input logic [DW-1:0]     main_eff_q,
    input logic [DW-1:0]     main_mask_q,
    input logic              pol_q,
    input logic              hold_en_q
);

    localparam int unsigned HALF = DW / 2;

    p_tx_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        main_eff_q[TX_SUM_BIT] == |(core_src_q[HALF-1:0] & ~core_mask_q[HALF-1:0]));

    p_rx_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        main_eff_q[RX_SUM_BIT] == |(core_src_q[DW-1:HALF] & ~core_mask_q[DW-1:HALF]));

    p_dma_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        main_eff_q[DMA_SUM_BIT] == |(dma_src_q & ~dma_mask_q));

    p_line_high_pol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pol_q |-> (irq_o == (hold_en_q && |(main_eff_q & ~main_mask_q))));

    p_line_low_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_q |-> (irq_o == (hold_en_q && !(|(main_eff_q & ~main_mask_q)))));

    p_power_rise_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_i && !$past(pwr_i)) |=> !irq_o);

    p_clear_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (int'(reg_addr) == A_CORE_CLR) && (core_hw_set == '0))
        |=> ((core_src_q & $past(reg_wdata)) == '0));

endmodule

bind irq_aggr_top irq_aggr_chk #(.DW(DW), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .core_hw_set (core_hw_set),
    .pwr_i       (pwr_i),
    .irq_o       (irq_o),
    .core_src_q  (core_src_q),
    .core_mask_q (core_mask_q),
    .dma_src_q   (dma_src_q),
    .dma_mask_q  (dma_mask_q),
    .main_eff_q  (main_eff_q),
    .main_mask_q (main_mask_q),
    .pol_q       (pol_q),
    .hold_en_q   (hold_en_q)
);

// File: tb/irq_aggr_top_tb_top.sv
module irq_aggr_top_tb_top;
    import irq_aggr_pkg::*;

    localparam int unsigned DW     = 32;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned HOLD   = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] reg_addr;
    logic              reg_wr;
    logic [DW-1:0]     reg_wdata;
    logic [DW-1:0]     reg_rdata;
    logic [DW-1:0]     main_hw_set, core_hw_set, dma_hw_set;
    logic              pwr_i;
    logic              irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_aggr_top #(.DW(DW), .ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .main_hw_set (main_hw_set),
        .core_hw_set (core_hw_set),
        .dma_hw_set  (dma_hw_set),
        .pwr_i       (pwr_i),
        .irq_o       (irq_o)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input int unsigned a, input logic [DW-1:0] d);
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_chk(input int unsigned a, input logic [DW-1:0] exp, input string req);
        reg_addr = ADDR_W'(a);
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: read addr %0d got %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic exp, input string req);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s: irq_o got %b expected %b", req, irq_o, exp);
        end
    endtask

    task automatic power_up(input logic final_irq, input string req);
        pwr_i = 1'b1;
        repeat (HOLD) @(posedge clk);
        @(negedge clk);
        irq_chk(1'b0, req);
        @(posedge clk);
        @(negedge clk);
        irq_chk(final_irq, req);
    endtask

    task automatic t_reset();
        rd_chk(A_MAIN_MASK, 32'hFFFF_FFFF, "R1");
        rd_chk(A_CORE_MASK, 32'h0, "R1");
        rd_chk(A_DMA_MASK, 32'h0, "R1");
        rd_chk(A_MAIN_SRC, 32'h0, "R1");
        rd_chk(A_CORE_SRC, 32'h0, "R1");
        rd_chk(A_DMA_SRC, 32'h0, "R1");
        rd_chk(A_CTRL, 32'h0, "R1");
        irq_chk(1'b0, "R1");
    endtask

    task automatic t_first_power();
        // polarity 0, all masked: nothing unmasked pending, line on after hold-off
        power_up(1'b1, "R8");
    endtask

    task automatic t_main_regs();
        wr(A_MAIN_SET, 32'h0000_00F1);
        irq_chk(1'b1, "R5");
        rd_chk(A_MAIN_SRC, 32'h0000_00F1, "R2");
        rd_chk(A_MAIN_SET, 32'h0000_00F1, "R2");
        rd_chk(A_MAIN_CLR, 32'h0000_00F1, "R2");
        wr(A_MAIN_CLR, 32'h0000_0031);
        rd_chk(A_MAIN_SRC, 32'h0000_00C0, "R2");
        wr(A_MAIN_MASK, ~32'h0000_0080);
        irq_chk(1'b0, "R7 R9");
        wr(A_CTRL, 32'h1);
        irq_chk(1'b1, "R6 R9");
        rd_chk(A_CTRL, 32'h1, "R6");
        wr(A_MAIN_CLR, 32'hFFFF_FFFF);
        irq_chk(1'b0, "R6");
    endtask

    task automatic t_core_group();
        wr(A_MAIN_MASK, ~32'h0000_0300);
        wr(A_CORE_SET, 32'h0000_0004);
        rd_chk(A_MAIN_SRC, 32'h0000_0200, "R3");
        irq_chk(1'b1, "R3");
        wr(A_CORE_MASK, 32'h0000_0004);
        rd_chk(A_MAIN_SRC, 32'h0, "R3");
        irq_chk(1'b0, "R3");
        wr(A_CORE_SET, 32'h0001_0000);
        rd_chk(A_MAIN_SRC, 32'h0000_0100, "R3");
        irq_chk(1'b1, "R3");
        rd_chk(A_CORE_SRC, 32'h0001_0004, "R2");
        rd_chk(A_CORE_CLR, 32'h0001_0004, "R2");
        wr(A_CORE_CLR, 32'hFFFF_FFFF);
        rd_chk(A_CORE_SRC, 32'h0, "R2");
        irq_chk(1'b0, "R3");
        wr(A_CORE_MASK, 32'h0);
    endtask

    task automatic t_dma_group();
        wr(A_MAIN_MASK, ~32'h0100_0000);
        wr(A_DMA_SET, 32'h0000_0008);
        rd_chk(A_MAIN_SRC, 32'h0100_0000, "R4");
        irq_chk(1'b1, "R4");
        wr(A_DMA_MASK, 32'h0000_0008);
        irq_chk(1'b0, "R4");
        wr(A_DMA_MASK, 32'h0);
        irq_chk(1'b1, "R4");
        wr(A_DMA_CLR, 32'h0000_0008);
        irq_chk(1'b0, "R4");
        rd_chk(A_DMA_SRC, 32'h0, "R4");
    endtask

    task automatic t_summary_locked();
        wr(A_MAIN_SET, 32'h0100_0300);
        rd_chk(A_MAIN_SRC, 32'h0, "R12");
        irq_chk(1'b0, "R12");
    endtask

    task automatic t_hw_set();
        wr(A_MAIN_MASK, ~32'h0000_0008);
        main_hw_set = 32'h8;
        @(posedge clk);
        @(negedge clk);
        main_hw_set = '0;
        rd_chk(A_MAIN_SRC, 32'h8, "R10");
        irq_chk(1'b1, "R10");
        main_hw_set = 32'h8;
        wr(A_MAIN_CLR, 32'h8);
        main_hw_set = '0;
        rd_chk(A_MAIN_SRC, 32'h8, "R10");
        wr(A_MAIN_CLR, 32'h8);
        irq_chk(1'b0, "R10");
        core_hw_set = 32'h0010_0000;
        @(posedge clk);
        @(negedge clk);
        core_hw_set = '0;
        rd_chk(A_MAIN_SRC, 32'h0000_0100, "R10");
        wr(A_CORE_CLR, 32'hFFFF_FFFF);
        wr(A_MAIN_SET, 32'h8);
        irq_chk(1'b1, "R6");
    endtask

    task automatic t_unmapped();
        wr(5, 32'hFFFF_FFFF);
        rd_chk(5, 32'h0, "R11");
        rd_chk(31, 32'h0, "R11");
        rd_chk(A_MAIN_SRC, 32'h8, "R11");
        rd_chk(A_MAIN_MASK, ~32'h0000_0008, "R11");
        irq_chk(1'b1, "R11");
    endtask

    task automatic t_power_cycles();
        pwr_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        irq_chk(1'b1, "R8");
        power_up(1'b1, "R8");
        // cancelled hold-off
        pwr_i = 1'b0;
        @(negedge clk);
        pwr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_chk(1'b0, "R8");
        repeat (5) @(negedge clk);
        pwr_i = 1'b0;
        repeat (HOLD + 5) @(negedge clk);
        irq_chk(1'b0, "R8");
        power_up(1'b1, "R8");
    endtask

    initial begin
        #(200_000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        report();
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        reg_addr    = '0;
        reg_wr      = 1'b0;
        reg_wdata   = '0;
        main_hw_set = '0;
        core_hw_set = '0;
        dma_hw_set  = '0;
        pwr_i       = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_power();
        t_main_regs();
        t_core_group();
        t_dma_group();
        t_summary_locked();
        t_hw_set();
        t_unmapped();
        t_power_cycles();
        report();
        $finish;
    end

endmodule